// File: doc/BRIEF.md
# Permission-Checking Address Translation Buffer

This block is a small fully associative translation buffer. It sits in front of the memory system and turns 48-bit virtual addresses into physical addresses on 4 KB pages. Every instruction fetch, data load and data store presents its address together with an access kind. The block compares the virtual page number with all valid slots at the same time. On a hit it joins the stored physical page number to the unchanged 12-bit page offset. It also checks the slot's write and execute permissions against the access kind and reports any violation as a fault code.

Slots are loaded from raw 64-bit page table entries through a valid/ready refill stream. The refill handshake completes when `fill_valid` and `fill_ready` are both high on a rising edge. `fill_ready` is low only while `flush` is asserted, which gives flush priority and makes the refill source hold its beat. The block classifies every offered entry at once on `fill_status`. An entry for a missing page or an absent page is still accepted by the handshake, but it is never cached. A single-cycle `flush` pulse invalidates every slot.

Top module: `tlb_xlate`

## Requirements
- R1: With `lk_valid` high and the page number `lk_vaddr[47:12]` held by a valid slot, in the same cycle `lk_hit` is 1 and `lk_paddr` equals {stored PPN, `lk_vaddr[11:0]`}. For a permitted access `lk_fault` is 0 (none) and `lk_paddr_ok` is 1.
- R2: With `lk_valid` high and no valid slot matching, `lk_hit` is 0, `lk_fault` is 1 (miss) and `lk_paddr_ok` is 0. This holds even if the page table would translate that page.
- R3: A refilled entry takes the present flag from bit 0, the writable flag from bit 1, the execute-disable flag from bit 63 and the 40-bit PPN from bits 51:12.
- R4: An all-zero entry gives `fill_status` = 1 (no page). Accepting it leaves every slot unchanged.
- R5: A nonzero entry with bit 0 clear gives `fill_status` = 2 (not present). Accepting it leaves every slot unchanged. A cacheable entry gives `fill_status` = 0.
- R6: A store (`lk_kind` = 1) that hits a slot with the writable flag clear gives `lk_fault` = 2. `lk_hit` stays 1, `lk_paddr` is still formed, and `lk_paddr_ok` is 0. A load (`lk_kind` = 0) to the same slot has no fault.
- R7: A fetch (`lk_kind` = 2) that hits a slot with execute-disable set gives `lk_fault` = 3 and `lk_paddr_ok` = 0. A load or store to that slot has no fault.
- R8: An accepted refill for a new page number goes into the lowest-numbered invalid slot. When all slots are valid it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 and advances by one after each such replacement.
- R9: A refill whose page number is already held overwrites that slot. No two valid slots ever share a page number.
- R10: `flush` clears every slot on the next rising edge. While `flush` is high, `fill_ready` is 0 and no refill is taken.
- R11: After reset every slot is invalid, so each lookup misses.
- R12: With `lk_valid` low, `lk_hit` and `lk_paddr_ok` are 0 and `lk_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is presented |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_kind | input | 2 | 0 load, 1 store, 2 fetch |
| lk_hit | output | 1 | Page number found in a valid slot |
| lk_paddr | output | 52 | Translated physical address |
| lk_paddr_ok | output | 1 | Hit with no permission fault |
| lk_fault | output | 2 | 0 none, 1 miss, 2 write-protect, 3 execute-disable |
| fill_valid | input | 1 | Refill beat offered |
| fill_ready | output | 1 | Refill beat can be taken |
| fill_vpn | input | 36 | Virtual page number of the refill |
| fill_pte | input | 64 | Raw page table entry |
| fill_status | output | 2 | 0 cacheable, 1 no page, 2 not present |
| flush | input | 1 | Invalidate all slots |

## Verification
The hardest state to reach from the ports is the round-robin replacement after every slot is full. A slot's number is never visible at the ports. The bench flushes, then refills eight distinct pages so that slots 0 to 7 fill in order, and then offers two more pages. It works out which earlier page each replacement must evict and confirms this by which lookups turn into misses. The overwrite path is checked in a similar way. The bench gives two refills of one page number different PPNs, then looks for the second PPN alone. A duplicate slot would OR the two PPNs together.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    LF_NONE  = 2'd0,
    LF_MISS  = 2'd1,
    LF_WPROT = 2'd2,
    LF_XDIS  = 2'd3
  } lk_fault_e;

  typedef enum logic [1:0] {
    FS_OK     = 2'd0,
    FS_NOPAGE = 2'd1,
    FS_ABSENT = 2'd2
  } fill_stat_e;

endpackage

// File: rtl/tlb_pte_decode.sv
module tlb_pte_decode #(
  parameter int PTE_W   = 64,
  parameter int PPN_W   = 40,
  parameter int PPN_LSB = 12
) (
  input  logic [PTE_W-1:0] pte,
  output logic [PPN_W-1:0] ppn,
  output logic             writable,
  output logic             xdis,
  output logic [1:0]       status
);
  import tlb_pkg::*;

  logic present;
  logic exists;

  assign present  = pte[0];
  assign writable = pte[1];
  assign xdis     = pte[PTE_W-1];
  assign ppn      = pte[PPN_LSB +: PPN_W];
  assign exists   = |pte;

  always_comb begin
    if (!exists)       status = FS_NOPAGE;
    else if (!present) status = FS_ABSENT;
    else               status = FS_OK;
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 36
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            hits
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] same_vpn,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   slot,
  output logic               use_rr
);
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             have_dup;
  logic             have_free;

  always_comb begin
    dup_idx   = '0;
    have_dup  = 1'b0;
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (same_vpn[i] && !have_dup) begin
        dup_idx  = IDX_W'(i);
        have_dup = 1'b1;
      end
      if (!valid[i] && !have_free) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
  end

  always_comb begin
    use_rr = 1'b0;
    if (have_dup)       slot = dup_idx;
    else if (have_free) slot = free_idx;
    else begin
      slot   = rr_ptr;
      use_rr = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W    = 48,
  parameter int PG_W    = 12,
  parameter int PPN_W   = 40,
  parameter int PTE_W   = 64,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic [1:0]             lk_kind,
  output logic                   lk_hit,
  output logic [PPN_W+PG_W-1:0]  lk_paddr,
  output logic                   lk_paddr_ok,
  output logic [1:0]             lk_fault,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [VA_W-PG_W-1:0]   fill_vpn,
  input  logic [PTE_W-1:0]       fill_pte,
  output logic [1:0]             fill_status,
  input  logic                   flush
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - PG_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0]            wr_q;
  logic [ENTRIES-1:0]            xd_q;
  logic [IDX_W-1:0]              rr_q;

  // lookup compare
  logic [ENTRIES-1:0] lk_hits;
  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(vpn_q), .key(lk_vaddr[VA_W-1:PG_W]), .hits(lk_hits)
  );

  // refill compare for overwrite detection
  logic [ENTRIES-1:0] fill_hits;
  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .valid(valid_q), .tags(vpn_q), .key(fill_vpn), .hits(fill_hits)
  );

  logic [PPN_W-1:0] new_ppn;
  logic             new_wr;
  logic             new_xd;
  logic [1:0]       new_stat;
  tlb_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W), .PPN_LSB(PG_W)) u_dec (
    .pte(fill_pte), .ppn(new_ppn), .writable(new_wr), .xdis(new_xd), .status(new_stat)
  );

  logic [IDX_W-1:0] tgt_slot;
  logic             tgt_rr;
  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid(valid_q), .same_vpn(fill_hits), .rr_ptr(rr_q), .slot(tgt_slot), .use_rr(tgt_rr)
  );

  assign fill_ready  = !flush;
  assign fill_status = new_stat;

  logic fill_take;
  assign fill_take = fill_valid && fill_ready && (new_stat == FS_OK);

  // OR-mux across matches; at most one slot matches
  logic [PPN_W-1:0] sel_ppn;
  logic             sel_wr;
  logic             sel_xd;
  always_comb begin
    sel_ppn = '0;
    sel_wr  = 1'b0;
    sel_xd  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hits[i]) begin
        sel_ppn = sel_ppn | ppn_q[i];
        sel_wr  = sel_wr | wr_q[i];
        sel_xd  = sel_xd | xd_q[i];
      end
    end
  end

  logic any_hit;
  assign any_hit = |lk_hits;

  always_comb begin
    lk_hit      = lk_valid && any_hit;
    lk_paddr    = lk_hit ? {sel_ppn, lk_vaddr[PG_W-1:0]} : '0;
    lk_fault    = LF_NONE;
    if (lk_valid) begin
      if (!any_hit)                                lk_fault = LF_MISS;
      else if (lk_kind == ACC_STORE && !sel_wr)    lk_fault = LF_WPROT;
      else if (lk_kind == ACC_FETCH && sel_xd)     lk_fault = LF_XDIS;
    end
    lk_paddr_ok = lk_hit && (lk_fault == LF_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (fill_take) begin
      valid_q[tgt_slot] <= 1'b1;
      vpn_q[tgt_slot]   <= fill_vpn;
      ppn_q[tgt_slot]   <= new_ppn;
      wr_q[tgt_slot]    <= new_wr;
      xd_q[tgt_slot]    <= new_xd;
      if (tgt_rr) rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

  // R9: a page number is held by at most one valid slot
  assert_match_unique_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));

  // R10: flush empties the buffer on the next edge
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);

  // R4: a no-page entry leaves the slots untouched
  assert_nopage_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && fill_pte == '0) |=> $stable(valid_q));

  // R5: a not-present entry leaves the slots untouched
  assert_absent_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && fill_status == FS_ABSENT) |=> $stable(valid_q));

  // R6: write-protect faults only on store hits, with the address marked unusable
  assert_wprot_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault == LF_WPROT) |-> (lk_kind == ACC_STORE && lk_hit && !lk_paddr_ok));

  // R2: a presented lookup without a hit reports a miss
  assert_miss_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> (lk_fault == LF_MISS && !lk_paddr_ok));
endmodule

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [47:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        lk_hit;
  logic [51:0] lk_paddr;
  logic        lk_paddr_ok;
  logic [1:0]  lk_fault;
  logic        fill_valid;
  logic        fill_ready;
  logic [35:0] fill_vpn;
  logic [63:0] fill_pte;
  logic [1:0]  fill_status;
  logic        flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_paddr_ok(lk_paddr_ok), .lk_fault(lk_fault),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pte(fill_pte), .fill_status(fill_status), .flush(flush)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [39:0] ppn, input logic w, input logic xd);
    return {xd, 11'b0, ppn, 10'b0, w, 1'b1};
  endfunction

  task automatic do_fill(input logic [35:0] vpn, input logic [63:0] pte, output logic [1:0] st);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pte = pte;
    #1 st = fill_status;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic [35:0] vpn, input logic [11:0] off, input logic [1:0] kind);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_kind = kind;
    #1;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    look(36'h1, 12'h0, 2'd0);
    chk("R11", "hit after reset", lk_hit, 0);
    chk("R11", "fault after reset", lk_fault, 1);
  endtask

  task automatic t_idle();
    @(negedge clk); lk_valid = 1'b0; lk_vaddr = 48'h000123456789; #1;
    chk("R12", "hit idle", lk_hit, 0);
    chk("R12", "fault idle", lk_fault, 0);
    chk("R12", "ok idle", lk_paddr_ok, 0);
  endtask

  task automatic t_hit();
    logic [1:0] st;
    do_fill(36'hABCDE0123, mk_pte(40'hFEDCBA9876, 1'b1, 1'b0), st);
    chk("R5", "status cacheable", st, 0);
    look(36'hABCDE0123, 12'h5A7, 2'd0);
    chk("R1", "hit", lk_hit, 1);
    chk("R3", "paddr", lk_paddr, {40'hFEDCBA9876, 12'h5A7});
    chk("R1", "ok", lk_paddr_ok, 1);
    chk("R1", "fault", lk_fault, 0);
    look(36'hABCDE0123, 12'h001, 2'd1);
    chk("R1", "store writable ok", lk_paddr_ok, 1);
  endtask

  task automatic t_miss();
    look(36'hABCDE0124, 12'h0, 2'd0);
    chk("R2", "miss hit", lk_hit, 0);
    chk("R2", "miss code", lk_fault, 1);
    chk("R2", "miss ok", lk_paddr_ok, 0);
  endtask

  task automatic t_nopage();
    logic [1:0] st;
    do_fill(36'h000000777, 64'h0, st);
    chk("R4", "status no page", st, 1);
    look(36'h000000777, 12'h0, 2'd0);
    chk("R4", "not cached", lk_hit, 0);
  endtask

  task automatic t_absent();
    logic [1:0] st;
    do_fill(36'h000000888, 64'h8000_0000_0ABC_0000, st);
    chk("R5", "status absent", st, 2);
    look(36'h000000888, 12'h0, 2'd0);
    chk("R5", "not cached", lk_hit, 0);
  endtask

  task automatic t_wprot();
    logic [1:0] st;
    do_fill(36'h000000100, mk_pte(40'h11, 1'b0, 1'b0), st);
    look(36'h000000100, 12'h0F0, 2'd1);
    chk("R6", "store fault", lk_fault, 2);
    chk("R6", "store hit", lk_hit, 1);
    chk("R6", "store paddr", lk_paddr, {40'h11, 12'h0F0});
    chk("R6", "store ok", lk_paddr_ok, 0);
    look(36'h000000100, 12'h0F0, 2'd0);
    chk("R6", "load fault", lk_fault, 0);
  endtask

  task automatic t_xd();
    logic [1:0] st;
    do_fill(36'h000000200, mk_pte(40'h22, 1'b1, 1'b1), st);
    look(36'h000000200, 12'h004, 2'd2);
    chk("R7", "fetch fault", lk_fault, 3);
    chk("R7", "fetch ok", lk_paddr_ok, 0);
    look(36'h000000200, 12'h004, 2'd1);
    chk("R7", "store no xd fault", lk_fault, 0);
  endtask

  task automatic t_rr();
    logic [1:0] st;
    do_flush();
    for (int i = 0; i < 8; i++) do_fill(36'h500 + 36'(i), mk_pte(40'h900 + 40'(i), 1'b1, 1'b0), st);
    for (int i = 0; i < 8; i++) begin
      look(36'h500 + 36'(i), 12'h0, 2'd0);
      chk("R8", "all eight held", lk_paddr, {40'h900 + 40'(i), 12'h0});
    end
    do_fill(36'h600, mk_pte(40'hA00, 1'b1, 1'b0), st);
    look(36'h500, 12'h0, 2'd0);
    chk("R8", "slot0 evicted", lk_hit, 0);
    look(36'h501, 12'h0, 2'd0);
    chk("R8", "slot1 kept", lk_hit, 1);
    look(36'h600, 12'h0, 2'd0);
    chk("R8", "new held", lk_paddr, {40'hA00, 12'h0});
    do_fill(36'h601, mk_pte(40'hA01, 1'b1, 1'b0), st);
    look(36'h501, 12'h0, 2'd0);
    chk("R8", "slot1 evicted next", lk_hit, 0);
    look(36'h502, 12'h0, 2'd0);
    chk("R8", "slot2 kept", lk_hit, 1);
  endtask

  task automatic t_dup();
    logic [1:0] st;
    do_flush();
    do_fill(36'h777, mk_pte(40'h0F0F, 1'b1, 1'b0), st);
    do_fill(36'h777, mk_pte(40'h3000, 1'b0, 1'b0), st);
    look(36'h777, 12'h0, 2'd0);
    chk("R9", "overwritten ppn", lk_paddr, {40'h3000, 12'h0});
    look(36'h777, 12'h0, 2'd1);
    chk("R9", "overwritten perm", lk_fault, 2);
  endtask

  task automatic t_flush();
    logic [1:0] st;
    do_fill(36'h800, mk_pte(40'h1, 1'b1, 1'b0), st);
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 36'h801; fill_pte = mk_pte(40'h2, 1'b1, 1'b0);
    #1 chk("R10", "ready low on flush", fill_ready, 0);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    look(36'h800, 12'h0, 2'd0);
    chk("R10", "old gone", lk_hit, 0);
    look(36'h801, 12'h0, 2'd0);
    chk("R10", "fill during flush dropped", lk_hit, 0);
  endtask

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_kind = 2'd0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pte = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_hit();
    t_miss();
    t_nopage();
    t_absent();
    t_wprot();
    t_xd();
    t_rr();
    t_dup();
    t_flush();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule